// File: doc/BRIEF.md
# Two-Format Integer Instruction Executor

This block executes a small subset of a 32-bit load/store instruction encoding, one instruction at a time. It accepts one instruction word on each cycle where `in_valid` is high. It separates the word into register-to-register fields or immediate fields, and reads two operands from an internal register file of 32 entries of 32 bits each. It then computes an add, a bitwise and/or/nor, a zero-filling shift or an immediate add. It can also read a word from a 64-word internal data memory. The result is written back to the register file on the same clock edge that accepts the instruction.

A test environment or a surrounding controller fills the data memory through a dedicated write port. It observes any register through a combinational read-back port. Each accepted instruction is acknowledged by a one-cycle `done` pulse that arrives together with the registered ALU result. An `illegal` flag marks words that cannot be executed.

Top module: `insn_exec_core`

## Requirements
- R1: While reset is held and after it is released, `done` and `illegal` are 0, `alu_result` is 0, and every register reads 0 through the read-back port.
- R2: A word with bits [31:26] = 0 is register-form: source A in [25:21], source B in [20:16], destination in [15:11], shift count in [10:6], function in [5:0]. Function 32 writes A + B to the destination, wrapping modulo 2^32. The word 0x02324020 adds registers 17 and 18 into register 8.
- R3: Register-form functions 36, 37 and 39 write A AND B, A OR B, and NOT(A OR B) respectively. A nor with register 0 as source B yields the bitwise complement of A.
- R4: Register-form functions 0 and 2 shift source B left or right, respectively, by the count in [10:6], filling vacated bits with zeros.
- R5: Opcode 8 writes source A plus the 16-bit field [15:0] to the register named in [20:16]. The field is sign-extended by copying bit 15 into bits 31:16, and the sum wraps modulo 2^32.
- R6: Opcode 35 forms the address as source A plus the sign-extended offset in [15:0]. It reads the data word at index address[7:2], writes it to the register named in [20:16], and reports the address on `alu_result`.
- R7: An opcode-35 address whose bits [1:0] are not 00 raises `illegal` and writes no register.
- R8: An opcode other than 0, 8 or 35, or a register-form function outside {0, 2, 32, 36, 37, 39], raises `illegal` for one cycle. It leaves all registers unchanged and sets `alu_result` to 0.
- R9: Register 0 always reads 0, and a result targeted at it is discarded. `alu_result` still shows the computed value.
- R10: `done` is high exactly in the cycle after each cycle with `in_valid` high, including illegal words. Results and `illegal` appear in that same cycle. A cycle without `in_valid` leaves `alu_result` unchanged.
- R11: A write on the memory port stores `mem_wr_data` at word index `mem_wr_addr` on the clock edge. Later loads of that index return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word present this cycle |
| insn | input | 32 | Instruction word |
| mem_wr_en | input | 1 | Data memory preload strobe |
| mem_wr_addr | input | 6 | Data memory word index for preload |
| mem_wr_data | input | 32 | Data memory preload value |
| rd_sel | input | 5 | Register selected for read-back |
| rd_data | output | 32 | Combinational value of the selected register |
| alu_result | output | 32 | Registered result of the last accepted instruction |
| illegal | output | 1 | Last accepted word could not be executed |
| done | output | 1 | One-cycle acknowledge of an accepted word |

## Verification
An instruction presented with `in_valid` high is taken on the next rising edge. `done`, `illegal` and `alu_result` are registered at that edge and hold for the following cycle. The register write lands on the same edge, so `rd_data` shows it immediately afterwards. The bench drives each word on a falling edge and removes `in_valid` on the next falling edge. It samples all outputs there, half a cycle after the accepting edge, and compares them against a reference model of its own. A back-to-back pair checks that a result written on one edge is already the operand of the very next word.

// File: rtl/insn_exec_pkg.sv
package insn_exec_pkg;

  localparam int WORD_W = 32;

  localparam logic [5:0] OPC_REGFORM = 6'd0;
  localparam logic [5:0] OPC_ADD_IMM = 6'd8;
  localparam logic [5:0] OPC_LOAD    = 6'd35;

  localparam logic [5:0] FN_SHL  = 6'd0;
  localparam logic [5:0] FN_SHR  = 6'd2;
  localparam logic [5:0] FN_ADD  = 6'd32;
  localparam logic [5:0] FN_AND  = 6'd36;
  localparam logic [5:0] FN_OR   = 6'd37;
  localparam logic [5:0] FN_NOR  = 6'd39;

  typedef enum logic [3:0] {
    K_ADD, K_AND, K_OR, K_NOR, K_SHL, K_SHR, K_ADD_IMM, K_LOAD, K_BAD
  } op_kind_e;

  typedef struct packed {
    op_kind_e           kind;
    logic [4:0]         src_a;
    logic [4:0]         src_b;
    logic [4:0]         dest;
    logic [4:0]         shamt;
    logic [WORD_W-1:0]  imm;
  } dec_t;

  function automatic logic [WORD_W-1:0] sext16(input logic [15:0] v);
    return {{(WORD_W-16){v[15]}}, v};
  endfunction

  function automatic logic [WORD_W-1:0] alu_eval(
      input op_kind_e kind, input logic [WORD_W-1:0] a,
      input logic [WORD_W-1:0] b, input logic [WORD_W-1:0] imm,
      input logic [4:0] shamt);
    logic [WORD_W-1:0] r;
    case (kind)
      K_ADD:              r = a + b;
      K_AND:              r = a & b;
      K_OR:               r = a | b;
      K_NOR:              r = ~(a | b);
      K_SHL:              r = b << shamt;
      K_SHR:              r = b >> shamt;
      K_ADD_IMM, K_LOAD:  r = a + imm;
      default:            r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/insn_decoder.sv
module insn_decoder
  import insn_exec_pkg::*;
(
  input  logic [31:0] insn,
  output dec_t        dec
);
  logic [5:0] opc;
  logic [5:0] fn;

  assign opc = insn[31:26];
  assign fn  = insn[5:0];

  always_comb begin
    dec.src_a = insn[25:21];
    dec.src_b = insn[20:16];
    dec.shamt = insn[10:6];
    dec.imm   = sext16(insn[15:0]);
    dec.dest  = insn[15:11];
    dec.kind  = K_BAD;
    case (opc)
      OPC_REGFORM: begin
        case (fn)
          FN_ADD:  dec.kind = K_ADD;
          FN_AND:  dec.kind = K_AND;
          FN_OR:   dec.kind = K_OR;
          FN_NOR:  dec.kind = K_NOR;
          FN_SHL:  dec.kind = K_SHL;
          FN_SHR:  dec.kind = K_SHR;
          default: dec.kind = K_BAD;
        endcase
      end
      OPC_ADD_IMM: begin
        dec.kind = K_ADD_IMM;
        dec.dest = insn[20:16];
      end
      OPC_LOAD: begin
        dec.kind = K_LOAD;
        dec.dest = insn[20:16];
      end
      default: dec.kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/insn_regfile.sv
module insn_regfile #(
  parameter int ENTRIES = 32,
  parameter int WIDTH   = 32,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    ra_addr,
  output logic [WIDTH-1:0] ra_data,
  input  logic [AW-1:0]    rb_addr,
  output logic [WIDTH-1:0] rb_data,
  input  logic [AW-1:0]    rc_addr,
  output logic [WIDTH-1:0] rc_data
);
  logic [WIDTH-1:0] regs [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_flop
      always_ff @(posedge clk) begin
        if (!rst_n)
          regs[g] <= '0;
        else if (we && waddr == AW'(g))
          regs[g] <= wdata;
      end
    end
  end

  assign ra_data = regs[ra_addr];
  assign rb_data = regs[rb_addr];
  assign rc_data = regs[rc_addr];
endmodule

// File: rtl/insn_dmem.sv
module insn_dmem #(
  parameter int WORDS = 64,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/insn_exec_core.sv
module insn_exec_core
  import insn_exec_pkg::*;
#(
  parameter int REG_COUNT = 32,
  parameter int MEM_WORDS = 64,
  localparam int REG_AW   = $clog2(REG_COUNT),
  localparam int MEM_AW   = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       insn,
  input  logic              mem_wr_en,
  input  logic [MEM_AW-1:0] mem_wr_addr,
  input  logic [31:0]       mem_wr_data,
  input  logic [REG_AW-1:0] rd_sel,
  output logic [31:0]       rd_data,
  output logic [31:0]       alu_result,
  output logic              illegal,
  output logic              done
);
  dec_t              dec;
  logic [31:0]       op_a;
  logic [31:0]       op_b;
  logic [31:0]       alu_out;
  logic [31:0]       load_data;
  logic [31:0]       rf_wdata;
  logic              is_load;
  logic              misaligned;
  logic              reject;
  logic              rf_we;
  logic [REG_AW-1:0] rf_waddr;
  logic [MEM_AW-1:0] load_index;

  insn_decoder u_dec (
    .insn (insn),
    .dec  (dec)
  );

  insn_regfile #(.ENTRIES(REG_COUNT), .WIDTH(32)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .ra_addr (dec.src_a[REG_AW-1:0]),
    .ra_data (op_a),
    .rb_addr (dec.src_b[REG_AW-1:0]),
    .rb_data (op_b),
    .rc_addr (rd_sel),
    .rc_data (rd_data)
  );

  insn_dmem #(.WORDS(MEM_WORDS), .WIDTH(32)) u_mem (
    .clk   (clk),
    .we    (mem_wr_en),
    .waddr (mem_wr_addr),
    .wdata (mem_wr_data),
    .raddr (load_index),
    .rdata (load_data)
  );

  assign alu_out    = alu_eval(dec.kind, op_a, op_b, dec.imm, dec.shamt);
  assign is_load    = (dec.kind == K_LOAD);
  assign load_index = alu_out[MEM_AW+1:2];
  assign misaligned = is_load && (alu_out[1:0] != 2'b00);
  assign reject     = (dec.kind == K_BAD) || misaligned;
  assign rf_waddr   = dec.dest[REG_AW-1:0];
  assign rf_we      = in_valid && !reject && (rf_waddr != '0);
  assign rf_wdata   = is_load ? load_data : alu_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      illegal    <= 1'b0;
      alu_result <= '0;
    end else begin
      done    <= in_valid;
      illegal <= in_valid && reject;
      if (in_valid)
        alu_result <= reject ? '0 : alu_out;
    end
  end
endmodule

// File: rtl/insn_exec_chk.sv
module insn_exec_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          done,
  input logic          illegal,
  input logic [31:0]   alu_result,
  input logic          rf_we,
  input logic [AW-1:0] rf_waddr
);
  // R10
  done_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> done);
  // R10
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !done);
  // R10
  idle_holds_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(alu_result));
  // R8
  illegal_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);
  // R8
  illegal_zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> alu_result == '0);
  // R7
  write_never_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !illegal);
  // R9
  zero_reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> rf_waddr != '0);
endmodule

bind insn_exec_core insn_exec_chk #(.AW(REG_AW)) u_exec_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .done       (done),
  .illegal    (illegal),
  .alu_result (alu_result),
  .rf_we      (rf_we),
  .rf_waddr   (rf_waddr)
);

// File: tb/test_insn_exec_core.sv
module test_insn_exec_core;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 24;

  // Register-form: {6'd0, A, B, dest, shamt, funct}; immediate-form: {op, A, B/dest, imm16}
  localparam logic [31:0] PROG [NV] = '{
    {6'd8,  5'd0,  5'd1,  16'h7fff},               // R5 max positive imm
    {6'd8,  5'd0,  5'd2,  16'h8000},               // R5 most negative imm
    {6'd8,  5'd1,  5'd3,  16'h0001},               // R5
    {6'd0,  5'd1,  5'd2,  5'd4, 5'd0, 6'd32},      // R2 add
    {6'd8,  5'd0,  5'd5,  16'hffff},               // R5 -1
    {6'd0,  5'd4,  5'd5,  5'd6, 5'd0, 6'd32},      // R2 wrap
    {6'd0,  5'd1,  5'd2,  5'd7, 5'd0, 6'd36},      // R3 and
    {6'd0,  5'd1,  5'd2,  5'd8, 5'd0, 6'd37},      // R3 or
    {6'd0,  5'd1,  5'd0,  5'd9, 5'd0, 6'd39},      // R3 not via nor
    {6'd0,  5'd0,  5'd1,  5'd10, 5'd4, 6'd0},      // R4 shl
    {6'd0,  5'd0,  5'd2,  5'd11, 5'd31, 6'd2},     // R4 shr fill
    {6'd0,  5'd0,  5'd4,  5'd12, 5'd31, 6'd0},     // R4 shl by 31
    {6'd8,  5'd0,  5'd13, 16'd16},                 // R5
    {6'd35, 5'd13, 5'd14, 16'd4},                  // R6 positive offset
    {6'd35, 5'd13, 5'd15, 16'hfffc},               // R6 negative offset
    {6'd35, 5'd0,  5'd16, 16'h0100},               // R6 index wraps
    {6'd0,  5'd1,  5'd1,  5'd0, 5'd0, 6'd32},      // R9 dest zero
    {6'd8,  5'd0,  5'd0,  16'h1234},               // R9 dest zero imm
    {6'd35, 5'd13, 5'd17, 16'd2},                  // R7 misaligned
    {6'd0,  5'd1,  5'd2,  5'd18, 5'd0, 6'd33},     // R8 bad funct
    {6'd4,  5'd1,  5'd2,  16'd8},                  // R8 bad opcode
    {6'd0,  5'd17, 5'd18, 5'd8,  5'd0, 6'd32},     // R2 sample word 0x02324020
    {6'd0,  5'd0,  5'd3,  5'd19, 5'd0, 6'd2},      // R4 shift by 0
    {6'd35, 5'd1,  5'd20, 16'h8001}                // R6 address 0x7fff+0xffff8001 = 0
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [31:0] insn = '0;
  logic        mem_wr_en = 0;
  logic [5:0]  mem_wr_addr = '0;
  logic [31:0] mem_wr_data = '0;
  logic [4:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic [31:0] alu_result;
  logic        illegal;
  logic        done;

  int total = 0;
  int fails = 0;

  logic [31:0] m_reg [32];
  logic [31:0] m_mem [64];
  logic [31:0] m_res;

  always #(CLK_PERIOD/2) clk = ~clk;

  insn_exec_core i_insn_exec_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .alu_result(alu_result),
    .illegal(illegal), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic read_reg(input logic [4:0] r, output logic [31:0] v);
    rd_sel = r;
    #1;
    v = rd_data;
  endtask

  // Reference model written from the requirements
  task automatic model(input logic [31:0] w, output logic bad, output logic [4:0] dst,
                       output string tag);
    logic [31:0] a, b, off, ea;
    logic        wr;
    int          fn;
    a   = m_reg[w[25:21]];
    b   = m_reg[w[20:16]];
    off = 32'($signed(w[15:0]));
    fn  = int'(w[5:0]);
    bad = 0; wr = 1; dst = w[15:11]; m_res = 0; tag = "R8";
    if (w[31:26] == 0) begin
      if (fn == 32)      begin m_res = a + b; tag = "R2"; end
      else if (fn == 36) begin m_res = a & b; tag = "R3"; end
      else if (fn == 37) begin m_res = a | b; tag = "R3"; end
      else if (fn == 39) begin m_res = ~a & ~b; tag = "R3"; end
      else if (fn == 0)  begin m_res = b << w[10:6]; tag = "R4"; end
      else if (fn == 2)  begin m_res = b >> w[10:6]; tag = "R4"; end
      else bad = 1;
    end else if (w[31:26] == 8) begin
      dst = w[20:16]; m_res = a + off; tag = "R5";
    end else if (w[31:26] == 35) begin
      dst = w[20:16]; ea = a + off; tag = "R6";
      if (ea[1:0] != 0) begin bad = 1; tag = "R7"; end
      else m_res = ea;
    end else bad = 1;
    if (bad) begin m_res = 0; wr = 0; end
    if (dst == 0) tag = "R9";
    if (wr && dst != 0)
      m_reg[dst] = (w[31:26] == 35) ? m_mem[ea[7:2]] : m_res;
  endtask

  task automatic run(input logic [31:0] w);
    logic        bad;
    logic [4:0]  dst;
    string       tag;
    logic [31:0] v;
    model(w, bad, dst, tag);
    insn = w; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk({tag, " result"}, alu_result, m_res);
    chk({tag, " illegal"}, {31'd0, illegal}, {31'd0, bad});
    chk("R10 done", {31'd0, done}, 32'd1);
    read_reg(dst, v);
    chk({tag, " dest"}, v, m_reg[dst]);
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] held;
    for (int i = 0; i < 32; i++) m_reg[i] = 0;
    for (int i = 0; i < 64; i++) m_mem[i] = 32'h5a00_0000 ^ (i * 32'h0101_0307);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", {31'd0, done}, 0);
    chk("R1 illegal", {31'd0, illegal}, 0);
    chk("R1 result", alu_result, 0);
    for (int r = 0; r < 32; r++) begin
      read_reg(5'(r), v);
      chk("R1 reg", v, 0);
    end
    // R11 preload memory
    for (int i = 0; i < 64; i++) begin
      mem_wr_en = 1; mem_wr_addr = 6'(i); mem_wr_data = m_mem[i];
      @(negedge clk);
    end
    mem_wr_en = 0;
    rst_n = 1;
    @(negedge clk);
    foreach (PROG[k]) run(PROG[k]);
    // R11 overwrite one word, then load it
    mem_wr_en = 1; mem_wr_addr = 6'd5; mem_wr_data = 32'hdead_beef; m_mem[5] = 32'hdead_beef;
    @(negedge clk);
    mem_wr_en = 0;
    run({6'd35, 5'd13, 5'd21, 16'd4});
    read_reg(5'd21, v);
    chk("R11 preload", v, 32'hdead_beef);
    // R10 idle cycles hold result and raise no done
    held = alu_result;
    repeat (3) @(negedge clk);
    chk("R10 idle done", {31'd0, done}, 0);
    chk("R10 idle result", alu_result, held);
    // R10 back-to-back: second word uses the first one's result
    insn = {6'd8, 5'd0, 5'd22, 16'd100}; in_valid = 1;
    @(negedge clk);
    chk("R10 b2b done1", {31'd0, done}, 1);
    insn = {6'd0, 5'd22, 5'd22, 5'd23, 5'd0, 6'd32};
    @(negedge clk);
    in_valid = 0;
    chk("R10 b2b done2", {31'd0, done}, 1);
    chk("R10 b2b result", alu_result, 32'd200);
    @(negedge clk);
    chk("R10 b2b done end", {31'd0, done}, 0);
    // R1 reset mid-run clears registers
    rst_n = 0;
    @(negedge clk);
    read_reg(5'd23, v);
    chk("R1 rereset reg", v, 0);
    chk("R1 rereset result", alu_result, 0);
    rst_n = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule